// File: doc/BRIEF.md
# Task Switch Control Sequencer

This block runs the control side of a hardware task switch. It keeps a small on-chip table of task descriptors. Each entry holds a present bit, a busy bit, a descriptor privilege level (DPL), a byte limit and a back-link selector. It also holds the current task register selector, the nested-task flag it hands to the incoming task, and a sticky task-switched flag.

A request names a cause (jump, call, interrupt/exception or return-from-nested-task) and a target. The target is a descriptor selector, or a gate selector together with the gate's own DPL and the task selector stored in that gate. The sequencer validates the target and reports the first violation as a fault code. On success it drives a save handshake for the outgoing register state, then commits the task register and the busy and back-link updates, then drives a load handshake for the incoming state. The register transfer itself happens outside the block.

The cause decides what happens to the outgoing busy bit and whether the incoming task is linked back to the caller. Interrupts and returns skip the privilege test. A return that targets a task whose busy bit is already set is allowed.

Top module: `task_switch_seq`

## Requirements
- R1: After reset, `tr_sel_o` equals `RESET_TR`, `ts_o`, `nt_o`, `fault_o`, `done_o`, `save_req_o` and `load_req_o` are 0, and `ready_o` is 1.
- R2: A selector carries its table index in bits [15:3], a local-table flag in bit 2 and a requestor privilege (RPL) in bits [1:0]. A target selector with bit 2 set faults with code 1. An index at or above `NUM_TASKS` is treated as a non-present entry.
- R3: `cause_i` encodes 0 jump, 1 call, 2 interrupt/exception, 3 return. For jump and call, the checked DPL must be numerically >= max(`cpl_i`, RPL of `sel_i`), otherwise the fault code is 2. The checked DPL is `gate_dpl_i` when `gate_i` is 1 and the target descriptor's DPL otherwise. Interrupt and return skip this test.
- R4: With `gate_i` set, the target is `gate_tss_sel_i`. Its RPL bits and the target descriptor's DPL have no effect on the outcome.
- R5: A target that is not present faults with code 3. A target whose limit is below 103 faults with code 4. A limit of exactly 103 is accepted.
- R6: A jump, call or interrupt to a target whose busy bit is set faults with code 5. A return is exempt from this test.
- R7: A return with `nt_i` clear faults with code 6. With `nt_i` set, the target is the back-link stored in the current task's entry.
- R8: Faults are checked in this priority order: code 6, 1, 2, 3, 4, 5. A fault is a one-cycle `fault_o` pulse with the code on `fault_code_o`. It leaves the task register, busy bits, back-links, `nt_o` and `ts_o` unchanged.
- R9: An accepted switch raises `save_req_o` until `save_ack_i`, then `load_req_o` until `load_ack_i`, then pulses `done_o`. The two requests are never high together, and `tr_sel_o` does not change while `save_req_o` is high.
- R10: On commit, the incoming entry becomes busy. The outgoing entry's busy bit is cleared for jump and return and kept for call and interrupt.
- R11: For call and interrupt, the incoming entry's back-link receives the outgoing task register selector and `nt_o` becomes 1. For jump and return, `nt_o` becomes 0.
- R12: On commit, `tr_sel_o` takes the target selector with bits [1:0] cleared and `ts_o` is set. `ts_clr_i` clears `ts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Switch request, taken while ready |
| cause_i | input | 2 | Cause of the switch |
| sel_i | input | 16 | Selector named by the request (descriptor or gate) |
| gate_i | input | 1 | The request goes through a task gate |
| gate_dpl_i | input | 2 | Privilege level of the gate |
| gate_tss_sel_i | input | 16 | Task selector held inside the gate |
| cpl_i | input | 2 | Current privilege level |
| nt_i | input | 1 | Nested-task flag of the running task |
| ts_clr_i | input | 1 | Clears the task-switched flag |
| cfg_we_i | input | 1 | Descriptor write strobe, used while ready |
| cfg_idx_i | input | $clog2(NUM_TASKS) | Descriptor index to write |
| cfg_present_i | input | 1 | Present bit to write |
| cfg_busy_i | input | 1 | Busy bit to write |
| cfg_dpl_i | input | 2 | DPL to write |
| cfg_limit_i | input | LIM_W | Limit to write |
| save_ack_i | input | 1 | Outgoing state has been saved |
| load_ack_i | input | 1 | Incoming state has been loaded |
| ready_o | output | 1 | Idle and able to take a request |
| tr_sel_o | output | 16 | Task register selector |
| nt_o | output | 1 | Nested-task flag for the incoming task |
| ts_o | output | 1 | Task-switched flag |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_code_o | output | 3 | Code of the most recent fault |
| save_req_o | output | 1 | Save the outgoing register state |
| load_req_o | output | 1 | Load the incoming register state |
| done_o | output | 1 | One-cycle pulse at the end of a switch |

## Verification
The bench builds the block with `NUM_TASKS` = 6 and `LIM_W` = 8. Because six entries is not a power of two, indices 6 and 7 are still encodable in the three index bits the table uses. This exercises the out-of-range path, which must look like a missing descriptor. The narrow limit field makes random limits land near the 102/103 boundary often. The small table also makes busy collisions and back-link chains across several calls and returns frequent under random stimulus. Acknowledge delays are randomized, so the save-before-load ordering is tested against stalls of varied length.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int SEL_W         = 16;
  localparam int MIN_TSS_LIMIT = 103;

  typedef enum logic [1:0] {
    CAUSE_JMP  = 2'd0,
    CAUSE_CALL = 2'd1,
    CAUSE_INT  = 2'd2,
    CAUSE_IRET = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_TI          = 3'd1,
    FLT_PRIV        = 3'd2,
    FLT_NOT_PRESENT = 3'd3,
    FLT_LIMIT       = 3'd4,
    FLT_BUSY        = 3'd5,
    FLT_NOT_NESTED  = 3'd6
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SAVE,
    ST_COMMIT,
    ST_LOAD
  } state_e;
endpackage

// File: rtl/tsw_desc_table.sv
module tsw_desc_table
  import tsw_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int LIM_W     = 20,
  parameter int IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_present_i,
  input  logic             cfg_busy_i,
  input  logic [1:0]       cfg_dpl_i,
  input  logic [LIM_W-1:0] cfg_limit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_present_o,
  output logic             rd_busy_o,
  output logic [1:0]       rd_dpl_o,
  output logic [LIM_W-1:0] rd_limit_o,
  input  logic [IDX_W-1:0] cur_idx_i,
  output logic [SEL_W-1:0] cur_link_o,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] in_idx_i,
  input  logic             clr_out_busy_i,
  input  logic             set_link_i,
  input  logic [SEL_W-1:0] link_val_i
);
  logic [NUM_TASKS-1:0] present_q;
  logic [NUM_TASKS-1:0] busy_q;
  logic [1:0]           dpl_q   [NUM_TASKS];
  logic [LIM_W-1:0]     limit_q [NUM_TASKS];
  logic [SEL_W-1:0]     link_q  [NUM_TASKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= '0;
      busy_q    <= '0;
      for (int e = 0; e < NUM_TASKS; e++) begin
        dpl_q[e]   <= '0;
        limit_q[e] <= '0;
        link_q[e]  <= '0;
      end
    end else if (commit_i) begin
      for (int e = 0; e < NUM_TASKS; e++) begin
        if (in_idx_i == IDX_W'(e)) begin
          busy_q[e] <= 1'b1;
          if (set_link_i) link_q[e] <= link_val_i;
        end else if (clr_out_busy_i && cur_idx_i == IDX_W'(e)) begin
          busy_q[e] <= 1'b0;
        end
      end
    end else if (cfg_we_i) begin
      for (int e = 0; e < NUM_TASKS; e++) begin
        if (cfg_idx_i == IDX_W'(e)) begin
          present_q[e] <= cfg_present_i;
          busy_q[e]    <= cfg_busy_i;
          dpl_q[e]     <= cfg_dpl_i;
          limit_q[e]   <= cfg_limit_i;
        end
      end
    end
  end

  // indices past the table read as an empty descriptor
  always_comb begin
    rd_present_o = 1'b0;
    rd_busy_o    = 1'b0;
    rd_dpl_o     = '0;
    rd_limit_o   = '0;
    if (int'(rd_idx_i) < NUM_TASKS) begin
      rd_present_o = present_q[rd_idx_i];
      rd_busy_o    = busy_q[rd_idx_i];
      rd_dpl_o     = dpl_q[rd_idx_i];
      rd_limit_o   = limit_q[rd_idx_i];
    end
  end

  always_comb begin
    cur_link_o = '0;
    if (int'(cur_idx_i) < NUM_TASKS) cur_link_o = link_q[cur_idx_i];
  end

  // R10
  incoming_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> busy_q[$past(in_idx_i)]);

  // R10
  outgoing_busy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && clr_out_busy_i && cur_idx_i != in_idx_i) |=> !busy_q[$past(cur_idx_i)]);
endmodule

// File: rtl/tsw_check.sv
module tsw_check
  import tsw_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  parameter int LIM_W     = 20,
  parameter int IDX_W     = 3
) (
  input  cause_e           cause_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             gate_i,
  input  logic [1:0]       gate_dpl_i,
  input  logic [SEL_W-1:0] gate_tss_sel_i,
  input  logic [1:0]       cpl_i,
  input  logic             nt_i,
  input  logic [SEL_W-1:0] cur_link_i,
  input  logic             d_present_i,
  input  logic             d_busy_i,
  input  logic [1:0]       d_dpl_i,
  input  logic [LIM_W-1:0] d_limit_i,
  output logic [SEL_W-1:0] tgt_sel_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output fault_e           fault_o
);
  logic [1:0] eff_pl;
  logic [1:0] chk_dpl;
  logic       in_range;
  logic       is_iret;
  logic       priv_ok;

  assign is_iret   = (cause_i == CAUSE_IRET);
  assign tgt_sel_o = is_iret ? cur_link_i : (gate_i ? gate_tss_sel_i : sel_i);
  assign tgt_idx_o = tgt_sel_o[3 +: IDX_W];
  assign in_range  = int'(tgt_sel_o[SEL_W-1:3]) < NUM_TASKS;
  assign eff_pl    = (cpl_i > sel_i[1:0]) ? cpl_i : sel_i[1:0];
  assign chk_dpl   = gate_i ? gate_dpl_i : d_dpl_i;
  assign priv_ok   = (chk_dpl >= eff_pl);

  always_comb begin
    fault_o = FLT_NONE;
    if (is_iret && !nt_i)                                  fault_o = FLT_NOT_NESTED;
    else if (tgt_sel_o[2])                                 fault_o = FLT_TI;
    else if ((cause_i == CAUSE_JMP || cause_i == CAUSE_CALL) && !priv_ok)
                                                           fault_o = FLT_PRIV;
    else if (!(in_range && d_present_i))                   fault_o = FLT_NOT_PRESENT;
    else if (d_limit_i < LIM_W'(MIN_TSS_LIMIT))            fault_o = FLT_LIMIT;
    else if (!is_iret && d_busy_i)                         fault_o = FLT_BUSY;
  end
endmodule

// File: rtl/tsw_fsm.sv
module tsw_fsm
  import tsw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fault_i,
  input  logic save_ack_i,
  input  logic load_ack_i,
  output logic idle_o,
  output logic check_o,
  output logic commit_o,
  output logic save_req_o,
  output logic load_req_o,
  output logic fault_o,
  output logic done_o
);
  state_e state_q, state_d;
  logic   fault_q, done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_CHECK;
      ST_CHECK:  state_d = fault_i ? ST_IDLE : ST_SAVE;
      ST_SAVE:   if (save_ack_i) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_LOAD;
      ST_LOAD:   if (load_ack_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= (state_q == ST_CHECK) && fault_i;
      done_q  <= (state_q == ST_LOAD) && load_ack_i;
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign check_o    = (state_q == ST_CHECK);
  assign commit_o   = (state_q == ST_COMMIT);
  assign save_req_o = (state_q == ST_SAVE);
  assign load_req_o = (state_q == ST_LOAD);
  assign fault_o    = fault_q;
  assign done_o     = done_q;

  // R9
  req_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({save_req_o, load_req_o}));

  // R9
  done_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(load_req_o && load_ack_i));

  // R9
  load_after_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_req_o) |-> $past(commit_o));
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tsw_pkg::*;
#(
  parameter int              NUM_TASKS = 8,
  parameter int              LIM_W     = 20,
  parameter logic [15:0]     RESET_TR  = 16'h0008,
  localparam int             IDX_W     = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       cause_i,
  input  logic [15:0]      sel_i,
  input  logic             gate_i,
  input  logic [1:0]       gate_dpl_i,
  input  logic [15:0]      gate_tss_sel_i,
  input  logic [1:0]       cpl_i,
  input  logic             nt_i,
  input  logic             ts_clr_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_present_i,
  input  logic             cfg_busy_i,
  input  logic [1:0]       cfg_dpl_i,
  input  logic [LIM_W-1:0] cfg_limit_i,
  input  logic             save_ack_i,
  input  logic             load_ack_i,
  output logic             ready_o,
  output logic [15:0]      tr_sel_o,
  output logic             nt_o,
  output logic             ts_o,
  output logic             fault_o,
  output logic [2:0]       fault_code_o,
  output logic             save_req_o,
  output logic             load_req_o,
  output logic             done_o
);
  cause_e           cause_q;
  logic [SEL_W-1:0] sel_q, gsel_q;
  logic             gate_q, nt_in_q;
  logic [1:0]       gdpl_q, cpl_q;
  logic [SEL_W-1:0] tr_q;
  logic             ts_q, nt_q;
  fault_e           code_q;

  logic             idle, check, commit;
  logic             rd_present, rd_busy;
  logic [1:0]       rd_dpl;
  logic [LIM_W-1:0] rd_limit;
  logic [SEL_W-1:0] cur_link, tgt_sel;
  logic [IDX_W-1:0] tgt_idx;
  fault_e           fault_d;
  logic             link_cause;

  assign link_cause = (cause_q == CAUSE_CALL) || (cause_q == CAUSE_INT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_JMP;
      sel_q   <= '0;
      gsel_q  <= '0;
      gate_q  <= 1'b0;
      gdpl_q  <= '0;
      cpl_q   <= '0;
      nt_in_q <= 1'b0;
    end else if (idle && req_i) begin
      cause_q <= cause_e'(cause_i);
      sel_q   <= sel_i;
      gsel_q  <= gate_tss_sel_i;
      gate_q  <= gate_i;
      gdpl_q  <= gate_dpl_i;
      cpl_q   <= cpl_i;
      nt_in_q <= nt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tr_q   <= RESET_TR;
      ts_q   <= 1'b0;
      nt_q   <= 1'b0;
      code_q <= FLT_NONE;
    end else begin
      if (commit) begin
        tr_q <= tgt_sel & ~16'h0003;
        nt_q <= link_cause;
        ts_q <= 1'b1;
      end else if (ts_clr_i) begin
        ts_q <= 1'b0;
      end
      if (check && fault_d != FLT_NONE) code_q <= fault_d;
    end
  end

  tsw_desc_table #(
    .NUM_TASKS(NUM_TASKS), .LIM_W(LIM_W), .IDX_W(IDX_W)
  ) i_table (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_we_i       (cfg_we_i && idle),
    .cfg_idx_i      (cfg_idx_i),
    .cfg_present_i  (cfg_present_i),
    .cfg_busy_i     (cfg_busy_i),
    .cfg_dpl_i      (cfg_dpl_i),
    .cfg_limit_i    (cfg_limit_i),
    .rd_idx_i       (tgt_idx),
    .rd_present_o   (rd_present),
    .rd_busy_o      (rd_busy),
    .rd_dpl_o       (rd_dpl),
    .rd_limit_o     (rd_limit),
    .cur_idx_i      (tr_q[3 +: IDX_W]),
    .cur_link_o     (cur_link),
    .commit_i       (commit),
    .in_idx_i       (tgt_idx),
    .clr_out_busy_i (!link_cause),
    .set_link_i     (link_cause),
    .link_val_i     (tr_q)
  );

  tsw_check #(
    .NUM_TASKS(NUM_TASKS), .LIM_W(LIM_W), .IDX_W(IDX_W)
  ) i_check (
    .cause_i        (cause_q),
    .sel_i          (sel_q),
    .gate_i         (gate_q),
    .gate_dpl_i     (gdpl_q),
    .gate_tss_sel_i (gsel_q),
    .cpl_i          (cpl_q),
    .nt_i           (nt_in_q),
    .cur_link_i     (cur_link),
    .d_present_i    (rd_present),
    .d_busy_i       (rd_busy),
    .d_dpl_i        (rd_dpl),
    .d_limit_i      (rd_limit),
    .tgt_sel_o      (tgt_sel),
    .tgt_idx_o      (tgt_idx),
    .fault_o        (fault_d)
  );

  tsw_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .fault_i    (fault_d != FLT_NONE),
    .save_ack_i (save_ack_i),
    .load_ack_i (load_ack_i),
    .idle_o     (idle),
    .check_o    (check),
    .commit_o   (commit),
    .save_req_o (save_req_o),
    .load_req_o (load_req_o),
    .fault_o    (fault_o),
    .done_o     (done_o)
  );

  assign ready_o      = idle;
  assign tr_sel_o     = tr_q;
  assign nt_o         = nt_q;
  assign ts_o         = ts_q;
  assign fault_code_o = code_q;

  // R9
  tr_hold_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |=> $stable(tr_sel_o));

  // R8
  fault_code_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_code_o != FLT_NONE);

  // R8
  fault_keeps_tr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(tr_sel_o) && !done_o);

  // R12
  ts_set_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ts_o) |-> $past(commit));

  // R12
  tr_rpl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(commit) |-> tr_sel_o[1:0] == 2'b00);
endmodule

// File: tb/test_task_switch_seq.sv
module test_task_switch_seq;
  localparam int          NT   = 6;
  localparam int          LW   = 8;
  localparam int          IW   = 3;
  localparam logic [15:0] RTR  = 16'h0008;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, gate_i = 1'b0, nt_i = 1'b0, ts_clr_i = 1'b0;
  logic [1:0] cause_i = '0, gate_dpl_i = '0, cpl_i = '0, cfg_dpl_i = '0;
  logic [15:0] sel_i = '0, gate_tss_sel_i = '0;
  logic cfg_we_i = 1'b0, cfg_present_i = 1'b0, cfg_busy_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic [LW-1:0] cfg_limit_i = '0;
  logic save_ack_i = 1'b0, load_ack_i = 1'b0;
  logic ready_o, nt_o, ts_o, fault_o, save_req_o, load_req_o, done_o;
  logic [15:0] tr_sel_o;
  logic [2:0] fault_code_o;

  int tests = 0, fails = 0, cycles = 0;

  bit          m_pres [8];
  bit          m_busy [8];
  logic [1:0]  m_dpl  [8];
  int          m_lim  [8];
  logic [15:0] m_link [8];
  logic [15:0] m_tr = RTR;
  bit          m_ts = 0, m_nt = 0;

  task_switch_seq #(.NUM_TASKS(NT), .LIM_W(LW), .RESET_TR(RTR)) i_task_switch_seq (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [2:0] model_fault(input logic [1:0] c, input logic [15:0] s,
      input logic g, input logic [1:0] gd, input logic [15:0] gs, input logic [1:0] cpl,
      input logic nt, output logic [15:0] t);
    int ix;
    logic [1:0] eff, d;
    t = (c == 2'd3) ? m_link[m_tr[15:3]] : (g ? gs : s);
    ix = int'(t[15:3]);
    eff = (cpl > s[1:0]) ? cpl : s[1:0];
    d = g ? gd : m_dpl[ix];
    if (c == 2'd3 && !nt) return 3'd6;
    if (t[2]) return 3'd1;
    if (c < 2'd2 && d < eff) return 3'd2;
    if (!(ix < NT && m_pres[ix])) return 3'd3;
    if (m_lim[ix] < 103) return 3'd4;
    if (c != 2'd3 && m_busy[ix]) return 3'd5;
    return 3'd0;
  endfunction

  task automatic cfg(input int ix, input bit p, input bit b, input logic [1:0] d, input int l);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = IW'(ix); cfg_present_i = p; cfg_busy_i = b;
    cfg_dpl_i = d; cfg_limit_i = LW'(l);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_pres[ix] = p; m_busy[ix] = b; m_dpl[ix] = d; m_lim[ix] = l;
  endtask

  task automatic ts_clear();
    @(negedge clk_i); ts_clr_i = 1'b1;
    @(negedge clk_i); ts_clr_i = 1'b0;
    m_ts = 0;
    chk(ts_o == 1'b0, "R12", "ts after clear", ts_o, 0);
  endtask

  task automatic run(input logic [1:0] c, input logic [15:0] s, input logic g,
                     input logic [1:0] gd, input logic [15:0] gs, input logic [1:0] cpl,
                     input logic nt, output logic [2:0] got);
    logic [15:0] t, tr0;
    logic [2:0] exp;
    bit f = 0, dn = 0, saw_save = 0, order_bad = 0;
    int oi, ni;
    exp = model_fault(c, s, g, gd, gs, cpl, nt, t);
    tr0 = m_tr;
    got = 3'd0;
    @(negedge clk_i);
    req_i = 1'b1; cause_i = c; sel_i = s; gate_i = g; gate_dpl_i = gd;
    gate_tss_sel_i = gs; cpl_i = cpl; nt_i = nt;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int k = 0; k < 60 && !f && !dn; k++) begin
      if (fault_o) begin f = 1; got = fault_code_o; end
      else if (done_o) dn = 1;
      else begin
        if (save_req_o) begin
          saw_save = 1;
          if (tr_sel_o != tr0) order_bad = 1;
          save_ack_i = ($urandom % 3) != 0;
        end else save_ack_i = 1'b0;
        if (load_req_o) begin
          if (!saw_save) order_bad = 1;
          load_ack_i = ($urandom % 3) != 0;
        end else load_ack_i = 1'b0;
        @(negedge clk_i);
      end
    end
    save_ack_i = 1'b0; load_ack_i = 1'b0;
    if (exp != 3'd0) begin
      chk(f && got == exp, req_of(exp), "fault code", {f, got}, {1'b1, exp});
      chk(tr_sel_o == m_tr, "R8", "tr after fault", tr_sel_o, m_tr);
      chk(nt_o == m_nt && ts_o == m_ts, "R8", "nt/ts after fault", {nt_o, ts_o}, {m_nt, m_ts});
    end else begin
      chk(dn && !f, "R9", "switch completes", {f, dn}, 2'b01);
      chk(!order_bad, "R9", "save before load, tr held", order_bad, 0);
      oi = int'(m_tr[15:3]); ni = int'(t[15:3]);
      if (c == 2'd0 || c == 2'd3) m_busy[oi] = 0;
      m_busy[ni] = 1;
      if (c == 2'd1 || c == 2'd2) m_link[ni] = m_tr;
      m_tr = t & ~16'h0003;
      m_nt = (c == 2'd1 || c == 2'd2);
      m_ts = 1;
      chk(tr_sel_o == m_tr, "R12", "tr after switch", tr_sel_o, m_tr);
      chk(nt_o == m_nt, "R11", "nt after switch", nt_o, m_nt);
      chk(ts_o == 1'b1, "R12", "ts after switch", ts_o, 1);
    end
  endtask

  initial begin
    logic [2:0] g;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      m_pres[i] = 0; m_busy[i] = 0; m_dpl[i] = 0; m_lim[i] = 0; m_link[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(tr_sel_o == RTR, "R1", "reset tr", tr_sel_o, RTR);
    chk({ts_o, nt_o, fault_o, done_o, save_req_o, load_req_o} == 6'b0, "R1", "reset flags",
        {ts_o, nt_o, fault_o, done_o, save_req_o, load_req_o}, 0);
    chk(ready_o == 1'b1, "R1", "reset ready", ready_o, 1);

    cfg(0, 1, 0, 2'd3, 150);
    cfg(1, 1, 1, 2'd0, 103);
    cfg(2, 1, 0, 2'd3, 200);
    cfg(3, 1, 0, 2'd0, 103);
    cfg(4, 1, 0, 2'd0, 102);
    cfg(5, 0, 0, 2'd0, 200);

    run(2'd0, 16'h0013, 0, 0, 0, 2'd3, 0, g);          // R10 JMP, busy1 cleared
    run(2'd0, 16'h0010, 0, 0, 0, 2'd0, 0, g);          // R6 re-entry
    chk(g == 3'd5, "R6", "busy re-entry", g, 5);
    ts_clear();                                        // R12
    run(2'd1, 16'h0018, 0, 0, 0, 2'd3, 0, g);          // R3 call to dpl0 from cpl3
    chk(g == 3'd2, "R3", "priv fault", g, 2);
    run(2'd1, 16'h0043, 1, 2'd3, 16'h001B, 2'd3, 0, g); // R4 gate, target dpl0 ignored
    chk(g == 3'd0, "R4", "gate call accepted", g, 0);
    run(2'd1, 16'h0043, 1, 2'd2, 16'h0000, 2'd1, 0, g); // R3 gate dpl < rpl
    chk(g == 3'd2, "R3", "gate dpl vs rpl", g, 2);
    run(2'd2, 16'h000B, 0, 0, 0, 2'd3, 0, g);          // R3 interrupt skips privilege
    chk(g == 3'd0, "R3", "interrupt exempt", g, 0);
    run(2'd3, 16'h0000, 0, 0, 0, 2'd0, 0, g);          // R7 not nested
    chk(g == 3'd6, "R7", "iret without nt", g, 6);
    run(2'd3, 16'h0000, 0, 0, 0, 2'd0, 1, g);          // R7 back to 3, busy target allowed
    chk(g == 3'd0 && tr_sel_o == 16'h0018, "R7", "iret to link", tr_sel_o, 16'h0018);
    run(2'd3, 16'h0000, 0, 0, 0, 2'd0, 1, g);          // R11 chain back to 2
    chk(tr_sel_o == 16'h0010, "R11", "second back-link", tr_sel_o, 16'h0010);
    run(2'd0, 16'h000C, 0, 0, 0, 2'd0, 0, g);          // R2 local-table flag
    chk(g == 3'd1, "R2", "ti fault", g, 1);
    run(2'd0, 16'h001F, 0, 0, 0, 2'd3, 0, g);          // R8 ti beats priv
    chk(g == 3'd1, "R8", "ti over priv", g, 1);
    run(2'd0, 16'h0028, 0, 0, 0, 2'd3, 0, g);          // R8 priv beats not-present
    chk(g == 3'd2, "R8", "priv over present", g, 2);
    run(2'd0, 16'h0020, 0, 0, 0, 2'd0, 0, g);          // R5 limit 102
    chk(g == 3'd4, "R5", "limit 102", g, 4);
    run(2'd0, 16'h0028, 0, 0, 0, 2'd0, 0, g);          // R5 not present
    chk(g == 3'd3, "R5", "not present", g, 3);
    run(2'd0, 16'h0038, 0, 0, 0, 2'd0, 0, g);          // R2 index beyond table
    chk(g == 3'd3, "R2", "out of range index", g, 3);
    cfg(4, 1, 0, 2'd0, 103);
    run(2'd0, 16'h0020, 0, 0, 0, 2'd0, 0, g);          // R5 limit 103 accepted
    chk(g == 3'd0, "R5", "limit 103", g, 0);
    run(2'd2, 16'h0000, 1, 2'd0, 16'h0011, 2'd3, 0, g); // R10 interrupt keeps busy4
    run(2'd0, 16'h0020, 0, 0, 0, 2'd0, 0, g);          // R10 busy kept on interrupt
    chk(g == 3'd5, "R10", "outgoing busy kept", g, 5);

    for (int n = 0; n < 500; n++) begin
      logic [1:0] c, rpl, cpl, gd;
      logic [15:0] s, gs;
      logic gt, ntf;
      if ($urandom % 8 == 0) begin
        int l;
        case ($urandom % 3) 0: l = 102; 1: l = 103; default: l = int'($urandom % 256); endcase
        cfg(int'($urandom % NT), ($urandom % 5) != 0, ($urandom % 3) == 0, 2'($urandom), l);
      end
      if ($urandom % 16 == 0) ts_clear();
      c = 2'($urandom); rpl = 2'($urandom); cpl = 2'($urandom); gd = 2'($urandom);
      s  = {10'd0, 3'($urandom), ($urandom % 8) == 0, rpl};
      gs = {10'd0, 3'($urandom), ($urandom % 8) == 0, 2'($urandom)};
      gt = ($urandom % 3) == 0;
      ntf = ($urandom % 4) != 0;
      run(c, s, gt, gd, gs, cpl, ntf, g);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule